// File: doc/BRIEF.md
# Control Message Command Responder

This block holds one received management control message in a small byte buffer and turns the request into its response without moving it. The buffer keeps the message type in byte 0, the flags in byte 1 and the command code in byte 2. Request arguments start at byte 3. A host fills the buffer through a byte write port and then pulses `start`. On that clock edge the block does four things: it clears the upper flag bits, writes the response data bytes from byte 3 on, updates its own endpoint identifier if the command sets it, and registers the response length. One cycle after `start`, `done` pulses for one cycle. The transmitter then reads the response back through the byte read port.

Four commands are answered: assign identifier, report identifier, report version and report supported message types. Any other command gets a single unsupported completion code. A message whose type is not the control type is left untouched and reports a zero length.

Top module: `ctl_responder`

## Requirements
- R1: For a control message, the response flags byte (byte 1) equals the request flags ANDed with 0x1F. Bytes 0 and 2 are unchanged, and every byte from 3 plus the response data count upward keeps its request value.
- R2: Command 0x01 loads the request byte at index 4 into the own identifier. It writes data bytes 0x00, 0x00, new identifier, 0x00 at bytes 3..6, and the length is 7.
- R3: Command 0x02 writes data bytes 0x00, own identifier, 0x00, 0x00 at bytes 3..6, and the length is 7.
- R4: Command 0x04 writes data bytes 0x00, 0x01, 0x00, 0x01, 0x03, 0x01 at bytes 3..8, and the length is 9.
- R5: Command 0x05 writes 0x00, then NUM_TYPES, then the type list at bytes 3 onward. Entry i is bits [8i+7:8i] of TYPE_LIST. The length is 5 plus NUM_TYPES (7 with the default list 0x00, 0x04).
- R6: Every other command code writes completion code 0x05 at byte 3, and the length is 4.
- R7: After reset, `own_eid` is 0x09, `done` is 0 and `resp_len` is 0.
- R8: `done` is high for exactly the cycle after each `start` cycle. `resp_len` holds the response length from that cycle until the next `start`.
- R9: A message whose type byte has bits [6:0] not zero is a non-control message. It leaves the buffer and the own identifier unchanged and reports length 0. Bit 7 of the type byte does not affect this.
- R10: A host buffer write presented in the same cycle as `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write enable |
| wr_addr | input | $clog2(DEPTH) | Host write byte index |
| wr_data | input | 8 | Host write byte |
| rd_addr | input | $clog2(DEPTH) | Read byte index |
| rd_data | output | 8 | Buffer byte at rd_addr (combinational) |
| start | input | 1 | Process the buffered request |
| done | output | 1 | One-cycle response-ready pulse |
| resp_len | output | 8 | Response length in bytes |
| own_eid | output | 8 | Own endpoint identifier |

## Verification
The hardest situations to reach from the ports involve ordering. A request that assigns the identifier must be followed by one that reports it, so that the reported value comes from the register and not from the request. A host write must land in exactly the same cycle as `start`. The bench sweeps all 256 command codes, and assign commands change the identifier in the middle of that sweep. After each message the bench reads the whole buffer back against a model of the request. It then drives a write on the `start` edge of a non-control message and confirms that the target byte kept its old value.

// File: rtl/ctl_resp_pkg.sv
package ctl_resp_pkg;
  localparam int HDR_BYTES   = 3;
  localparam int MAX_DATA    = 6;
  localparam int MAX_TYPES   = 4;
  localparam int CNT_W       = $clog2(MAX_DATA + 1);

  localparam logic [7:0] CMD_SET_ID  = 8'h01;
  localparam logic [7:0] CMD_GET_ID  = 8'h02;
  localparam logic [7:0] CMD_VERSION = 8'h04;
  localparam logic [7:0] CMD_TYPES   = 8'h05;

  localparam logic [7:0] ID_RESET    = 8'h09;
  localparam logic [7:0] CC_UNSUPP   = 8'h05;
  localparam logic [7:0] FLAG_KEEP   = 8'h1F;

  // Number of response data bytes for a command.
  function automatic int data_count(input logic [7:0] cmd, input int ntypes);
    case (cmd)
      CMD_SET_ID, CMD_GET_ID: return 4;
      CMD_VERSION:            return 6;
      CMD_TYPES:              return 2 + ntypes;
      default:                return 1;
    endcase
  endfunction

  // Fixed version reply, byte k.
  function automatic logic [7:0] version_byte(input int k);
    case (k)
      1, 3:    return 8'h01;
      4:       return 8'h03;
      5:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ctl_msg_store.sv
module ctl_msg_store
  import ctl_resp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      ld_en,
  input  logic [7:0]                ld_flags,
  input  logic [MAX_DATA-1:0][7:0]  ld_data,
  input  logic [CNT_W-1:0]          ld_cnt,
  input  logic [AW-1:0]             rd_addr,
  output logic [7:0]                rd_data,
  output logic [7:0]                type_b,
  output logic [7:0]                flags_b,
  output logic [7:0]                cmd_b,
  output logic [7:0]                arg_b
);
  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam bool_data = (g >= HDR_BYTES) && (g < HDR_BYTES + MAX_DATA);
    if (g == 1) begin : g_flags
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               mem[g] <= 8'h00;
        else if (ld_en)                           mem[g] <= ld_flags;
        else if (wr_en && wr_addr == AW'(g))      mem[g] <= wr_data;
      end
    end else if (bool_data) begin : g_data
      localparam int DI = g - HDR_BYTES;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               mem[g] <= 8'h00;
        else if (ld_en) begin
          if (CNT_W'(DI) < ld_cnt)                mem[g] <= ld_data[DI];
        end
        else if (wr_en && wr_addr == AW'(g))      mem[g] <= wr_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               mem[g] <= 8'h00;
        else if (!ld_en && wr_en && wr_addr == AW'(g)) mem[g] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign type_b  = mem[0];
  assign flags_b = mem[1];
  assign cmd_b   = mem[2];
  assign arg_b   = mem[4];
endmodule

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
  import ctl_resp_pkg::*;
#(
  parameter int          NUM_TYPES = 2,
  parameter logic [31:0] TYPE_LIST = 32'h0000_0400
) (
  input  logic [7:0]                type_b,
  input  logic [7:0]                flags_b,
  input  logic [7:0]                cmd_b,
  input  logic [7:0]                arg_b,
  input  logic [7:0]                own_eid,
  output logic                      is_ctl,
  output logic                      set_hit,
  output logic [7:0]                resp_flags,
  output logic [MAX_DATA-1:0][7:0]  resp_data,
  output logic [CNT_W-1:0]          resp_cnt
);
  assign is_ctl     = (type_b[6:0] == 7'd0);
  assign resp_flags = flags_b & FLAG_KEEP;
  assign resp_cnt   = CNT_W'(data_count(cmd_b, NUM_TYPES));

  always_comb begin
    resp_data = '0;
    set_hit   = 1'b0;
    case (cmd_b)
      CMD_SET_ID: begin
        resp_data[2] = arg_b;
        set_hit      = is_ctl;
      end
      CMD_GET_ID:  resp_data[1] = own_eid;
      CMD_VERSION: begin
        for (int k = 0; k < MAX_DATA; k++) resp_data[k] = version_byte(k);
      end
      CMD_TYPES: begin
        resp_data[1] = 8'(NUM_TYPES);
        for (int i = 0; i < MAX_TYPES; i++)
          if (i < NUM_TYPES) resp_data[2+i] = TYPE_LIST[8*i +: 8];
      end
      default: resp_data[0] = CC_UNSUPP;
    endcase
  end
endmodule

// File: rtl/ctl_responder.sv
module ctl_responder
  import ctl_resp_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          NUM_TYPES = 2,
  parameter logic [31:0] TYPE_LIST = 32'h0000_0400,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          start,
  output logic          done,
  output logic [7:0]    resp_len,
  output logic [7:0]    own_eid
);
  logic [7:0]               type_b, flags_b, cmd_b, arg_b;
  logic                     is_ctl, set_hit;
  logic [7:0]               resp_flags;
  logic [MAX_DATA-1:0][7:0] resp_data;
  logic [CNT_W-1:0]         resp_cnt;

  // Named events for the checker.
  logic ctl_go, eid_write, host_wr;
  assign ctl_go    = start & is_ctl;
  assign eid_write = start & set_hit;
  assign host_wr   = wr_en & ~start;

  ctl_msg_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr), .wr_addr(wr_addr), .wr_data(wr_data),
    .ld_en(ctl_go), .ld_flags(resp_flags), .ld_data(resp_data), .ld_cnt(resp_cnt),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .type_b(type_b), .flags_b(flags_b), .cmd_b(cmd_b), .arg_b(arg_b)
  );

  ctl_cmd_decode #(.NUM_TYPES(NUM_TYPES), .TYPE_LIST(TYPE_LIST)) u_dec (
    .type_b(type_b), .flags_b(flags_b), .cmd_b(cmd_b), .arg_b(arg_b),
    .own_eid(own_eid), .is_ctl(is_ctl), .set_hit(set_hit),
    .resp_flags(resp_flags), .resp_data(resp_data), .resp_cnt(resp_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      resp_len <= 8'h00;
      own_eid  <= ID_RESET;
    end else begin
      done <= start;
      if (start) resp_len <= ctl_go ? 8'(HDR_BYTES) + 8'(resp_cnt) : 8'h00;
      if (eid_write) own_eid <= arg_b;
    end
  end
endmodule

// File: rtl/ctl_responder_chk.sv
module ctl_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       ctl_go,
  input logic       eid_write,
  input logic       done,
  input logic [7:0] resp_len,
  input logic [7:0] own_eid
);
  assert_done_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_done_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  assert_eid_only_on_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(own_eid) |-> $past(eid_write));
  assert_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (resp_len == 8'd0 || (resp_len >= 8'd4 && resp_len <= 8'd9)));
  assert_noctl_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(!ctl_go)) |-> resp_len == 8'd0);
  assert_len_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!start) |-> $stable(resp_len));
endmodule

bind ctl_responder ctl_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ctl_go(ctl_go),
  .eid_write(eid_write), .done(done), .resp_len(resp_len), .own_eid(own_eid)
);

// File: tb/ctl_responder_tb.sv
module ctl_responder_tb;
  localparam int          DEPTH = 16;
  localparam int          NT    = 2;
  localparam logic [31:0] TL    = 32'h0000_0400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       start = 1'b0;
  logic       done;
  logic [7:0] resp_len;
  logic [7:0] own_eid;

  int checks = 0;
  int errors = 0;
  logic [7:0] eid_m = 8'h09;
  logic [7:0] req [DEPTH];
  logic [7:0] expb [DEPTH];

  always #10 clk = ~clk;

  ctl_responder #(.DEPTH(DEPTH), .NUM_TYPES(NT), .TYPE_LIST(TL)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .done(done),
    .resp_len(resp_len), .own_eid(own_eid)
  );

  task automatic check(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  function automatic int exp_cnt(input logic [7:0] c);
    case (c)
      8'h01, 8'h02: return 4;
      8'h04:        return 6;
      8'h05:        return 2 + NT;
      default:      return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_dat(input logic [7:0] c, input int k,
                                         input logic [7:0] eid, input logic [7:0] arg);
    case (c)
      8'h01: return (k == 2) ? arg : 8'h00;
      8'h02: return (k == 1) ? eid : 8'h00;
      8'h04: return (k == 1 || k == 3 || k == 5) ? 8'h01 : (k == 4) ? 8'h03 : 8'h00;
      8'h05: return (k == 0) ? 8'h00 : (k == 1) ? 8'(NT) : TL[8*(k-2) +: 8];
      default: return 8'h05;
    endcase
  endfunction

  task automatic load_msg(input logic [7:0] t, input logic [7:0] f, input logic [7:0] c,
                          input logic [7:0] d0, input logic [7:0] d1);
    for (int i = 0; i < DEPTH; i++) begin
      case (i)
        0: req[i] = t;
        1: req[i] = f;
        2: req[i] = c;
        3: req[i] = d0;
        4: req[i] = d1;
        default: req[i] = 8'hA0 + 8'(i);
      endcase
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(i); wr_data = req[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Fire the request, check done/len/eid, then read back the whole buffer.
  task automatic run_msg(input string tag);
    bit ctl;
    int n;
    ctl = (req[0][6:0] == 7'd0);
    n = ctl ? exp_cnt(req[2]) : 0;
    for (int i = 0; i < DEPTH; i++) expb[i] = req[i];
    if (ctl) begin
      expb[1] = req[1] & 8'h1F;
      for (int k = 0; k < n; k++) expb[3+k] = exp_dat(req[2], k, eid_m, req[4]);
      if (req[2] == 8'h01) eid_m = req[4];
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({tag, " R8 done"}, int'(done), 1);
    check({tag, " len"}, int'(resp_len), ctl ? 3 + n : 0);
    check({tag, " R2 eid"}, int'(own_eid), int'(eid_m));
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = 4'(i); #1;
      check($sformatf("%s R1 byte%0d", tag, i), int'(rd_data), int'(expb[i]));
    end
    @(negedge clk);
    check({tag, " R8 pulse"}, int'(done), 0);
    check({tag, " R8 hold"}, int'(resp_len), ctl ? 3 + n : 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 done", int'(done), 0);
    check("R7 len", int'(resp_len), 0);
    check("R7 eid", int'(own_eid), 8'h09);
    rst_n = 1'b1;

    // R3: report identifier under every flags value
    for (int f = 0; f < 256; f += 7) begin
      load_msg(8'h00, 8'(f), 8'h02, 8'h11, 8'h22);
      run_msg("R3 flags");
    end

    // R2 R4 R5 R6: every command code; assign commands move the identifier
    for (int c = 0; c < 256; c++) begin
      load_msg(8'h00, 8'hC0 | 8'(c & 8'h1F), 8'(c), 8'(c ^ 8'h5A), 8'(8'h30 + c));
      run_msg($sformatf("R6 cmd%0h", c));
    end

    // R2 then R3: assigned value is reported back
    for (int e = 1; e < 256; e += 51) begin
      load_msg(8'h80, 8'h80, 8'h01, 8'h00, 8'(e));
      run_msg("R2 set");
      load_msg(8'h00, 8'h40, 8'h02, 8'h00, 8'h00);
      run_msg("R3 get");
    end
    load_msg(8'h00, 8'h00, 8'h04, 8'h00, 8'h00); run_msg("R4 ver");
    load_msg(8'h00, 8'h00, 8'h05, 8'h00, 8'h00); run_msg("R5 types");

    // R9: non-control types, including an assign command
    load_msg(8'h01, 8'hE3, 8'h01, 8'h00, 8'h77); run_msg("R9 t01");
    load_msg(8'h7F, 8'hFF, 8'h02, 8'h00, 8'h00); run_msg("R9 t7f");
    load_msg(8'hC4, 8'hA5, 8'h04, 8'h00, 8'h00); run_msg("R9 tc4");

    // R10: host write on the start edge is dropped
    load_msg(8'h05, 8'h00, 8'h00, 8'h3C, 8'h00);
    @(negedge clk); start = 1'b1; wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'hEE;
    @(negedge clk); start = 1'b0; wr_en = 1'b0;
    rd_addr = 4'd3; #1;
    check("R10 byte3", int'(rd_data), 8'h3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule